// File: doc/BRIEF.md
# Slave DMA Handshake Gate

This block sits in front of a memory-mapped slave data port through which a host moves one block of data per command into or out of a storage controller's data path. An internal command engine asks for a transfer by presenting a byte count, a command tag and a direction. The gate then raises a trigger flag toward the host. The host reads the size and tag from the register window and acknowledges by writing 1 to the trigger bit. Only then does the data port open. While the port is open, every accepted beat is passed downstream and a byte counter runs down by the number of enabled byte lanes. When the counter is used up, the port closes and a done pulse goes back to the engine.

Every data-port access is classified. An access is premature when it arrives before the port opens. It is unsupported when its kind code is not the single-beat code. It is wrong-direction when its read/write sense disagrees with the pending command. None of these is forwarded. A premature access sets a sticky error flag. An unsupported or wrong-direction access sets the error flag and also a pause flag, which stops new triggers until software clears it. A settings bit chooses whether a rejected access gets an ERROR or an OK response. A downstream bus error that occurs while a command is in flight is recorded in a last-operation status word. An interrupt output combines the enabled flags.

Top module: `sdma_gate`

## Requirements
- R1: After reset every register reads 0, except the settings register at 0x43C, which reads 1 (bit 0, error-response select). The irq output is low.
- R2: When idle and not paused, a held cmd_req is taken. cmd_ack pulses, status 0x110 bit 0 (trigger) reads 1, 0x440 reads the byte count, and 0x444 reads the tag in its low bits with the direction in bit 31 (1 = host writes).
- R3: Writing 1 to 0x110 bit 0 while the trigger is set clears the trigger and opens the port. A supported, correctly directed beat is accepted from the next cycle on.
- R4: A supported access made while the port is not open is not forwarded and sets status bit 1 (error). Its response is ERROR when 0x43C bit 0 is 1 and OK when it is 0.
- R5: An access whose kind code (dp_kind) is not 0 is not forwarded. It sets status bit 1 and control status 0x118 bit 0 (pause). Its response follows 0x43C bit 0.
- R6: An access while a command is pending, either triggered or open, whose dp_write differs from the command's direction is handled as in R5.
- R7: While pause is set, no new trigger is raised and cmd_ack stays low. Writing 1 to 0x118 bit 0 clears pause, and a held request is then taken.
- R8: An accepted beat appears on fwd_* one cycle later with an OK response. The remaining count drops by the number of set bits in dp_be, stopping at zero. The beat that reaches zero closes the port and pulses xfer_done one cycle later.
- R9: The error flag is cleared by writing 1 to 0x110 bit 1. Writing 0 leaves it set.
- R10: irq is registered and, one cycle after the flags change, equals (trigger AND 0x114 bit 0) OR (error AND 0x114 bit 1).
- R11: A bus_err pulse while a command is triggered or open sets bits 0 (fail) and 1 (bus error) of 0x448, which are cleared by writing 1. A bus_err pulse while idle has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after reg_rd |
| cmd_req | input | 1 | Command engine transfer request, held until cmd_ack |
| cmd_size | input | SIZE_W | Transfer length in bytes |
| cmd_tag | input | TAG_W | Command tag |
| cmd_dir | input | 1 | 1 = host writes, 0 = host reads |
| cmd_ack | output | 1 | Request taken and trigger raised |
| xfer_done | output | 1 | Byte count exhausted, port closed |
| dp_valid | input | 1 | Data-port access strobe |
| dp_write | input | 1 | Access is a write |
| dp_kind | input | 2 | Access kind; 0 = supported single beat |
| dp_be | input | BE_W | Byte enables |
| dp_wdata | input | DW | Write data |
| dp_resp_valid | output | 1 | Response strobe, one cycle after dp_valid |
| dp_resp_err | output | 1 | 1 = ERROR response |
| fwd_valid | output | 1 | Accepted beat toward the data path |
| fwd_write | output | 1 | Direction of the forwarded beat |
| fwd_be | output | BE_W | Byte enables of the forwarded beat |
| fwd_wdata | output | DW | Data of the forwarded beat |
| bus_err | input | 1 | Downstream system bus error pulse |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that cmd_req stays high until cmd_ack and that its size, tag and direction are stable while it is high. They also assume that dp_valid, reg_wr and reg_rd last one cycle per access and never overlap a reset. The stimulus drives every input on the falling edge as single-cycle pulses. It holds each request together with its fields until the acknowledge is seen. Transfer sizes stay nonzero, so every opened port is eventually closed by a beat.

// File: rtl/sdma_pkg.sv
package sdma_pkg;
  localparam int REG_AW = 12;
  localparam logic [REG_AW-1:0] OFS_STAT = 12'h110;
  localparam logic [REG_AW-1:0] OFS_IEN  = 12'h114;
  localparam logic [REG_AW-1:0] OFS_CTRL = 12'h118;
  localparam logic [REG_AW-1:0] OFS_SET  = 12'h43C;
  localparam logic [REG_AW-1:0] OFS_SIZE = 12'h440;
  localparam logic [REG_AW-1:0] OFS_TAG  = 12'h444;
  localparam logic [REG_AW-1:0] OFS_LAST = 12'h448;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_ARMED = 2'd1,
    PH_OPEN  = 2'd2
  } phase_t;
endpackage

// File: rtl/sdma_seq.sv
module sdma_seq
  import sdma_pkg::*;
#(
  parameter int SIZE_W = 16,
  parameter int TAG_W  = 8,
  parameter int BE_W   = 4,
  localparam int CNT_W = $clog2(BE_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_req,
  input  logic [SIZE_W-1:0] cmd_size,
  input  logic [TAG_W-1:0]  cmd_tag,
  input  logic              cmd_dir,
  input  logic              paused,
  input  logic              trig_clr,
  input  logic              beat_ok,
  input  logic [CNT_W-1:0]  beat_bytes,
  output phase_t            phase,
  output logic              cmd_ack,
  output logic              xfer_done,
  output logic [SIZE_W-1:0] size_q,
  output logic [TAG_W-1:0]  tag_q,
  output logic              dir_q
);
  logic [SIZE_W-1:0] remain;
  logic [SIZE_W-1:0] step;

  assign step = SIZE_W'(beat_bytes);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      cmd_ack   <= 1'b0;
      xfer_done <= 1'b0;
      size_q    <= '0;
      tag_q     <= '0;
      dir_q     <= 1'b0;
      remain    <= '0;
    end else begin
      cmd_ack   <= 1'b0;
      xfer_done <= 1'b0;
      case (phase)
        PH_IDLE: begin
          if (cmd_req && !paused) begin
            size_q  <= cmd_size;
            tag_q   <= cmd_tag;
            dir_q   <= cmd_dir;
            cmd_ack <= 1'b1;
            phase   <= PH_ARMED;
          end
        end
        PH_ARMED: begin
          if (trig_clr) begin
            remain <= size_q;
            phase  <= PH_OPEN;
          end
        end
        PH_OPEN: begin
          if (beat_ok) begin
            if (remain <= step) begin
              remain    <= '0;
              phase     <= PH_IDLE;
              xfer_done <= 1'b1;
            end else begin
              remain <= remain - step;
            end
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  p_no_trig_paused_r7: assert property (@(posedge clk) disable iff (rst)
    cmd_ack |-> $past(!paused));

  p_open_after_clear_r3: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_OPEN && $past(phase) == PH_ARMED) |-> $past(trig_clr));

  p_count_down_r8: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_OPEN && $past(phase) == PH_OPEN) |-> (remain <= $past(remain)));
endmodule

// File: rtl/sdma_check.sv
module sdma_check
  import sdma_pkg::*;
#(
  parameter int DW   = 32,
  parameter int BE_W = DW / 8,
  localparam int CNT_W = $clog2(BE_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             dp_valid,
  input  logic             dp_write,
  input  logic [1:0]       dp_kind,
  input  logic [BE_W-1:0]  dp_be,
  input  logic [DW-1:0]    dp_wdata,
  input  phase_t           phase,
  input  logic             dir_q,
  input  logic             err_rsp,
  output logic             beat_ok,
  output logic             set_err,
  output logic             set_pause,
  output logic [CNT_W-1:0] beat_bytes,
  output logic             dp_resp_valid,
  output logic             dp_resp_err,
  output logic             fwd_valid,
  output logic             fwd_write,
  output logic [BE_W-1:0]  fwd_be,
  output logic [DW-1:0]    fwd_wdata
);
  logic bad, early;

  always_comb begin
    beat_bytes = '0;
    for (int i = 0; i < BE_W; i++) beat_bytes = beat_bytes + CNT_W'(dp_be[i]);
  end

  assign bad   = dp_valid && ((dp_kind != 2'd0) ||
                              ((phase != PH_IDLE) && (dp_write != dir_q)));
  assign early = dp_valid && !bad && (phase != PH_OPEN);
  assign beat_ok   = dp_valid && !bad && (phase == PH_OPEN);
  assign set_err   = bad || early;
  assign set_pause = bad;

  always_ff @(posedge clk) begin
    if (rst) begin
      dp_resp_valid <= 1'b0;
      dp_resp_err   <= 1'b0;
      fwd_valid     <= 1'b0;
      fwd_write     <= 1'b0;
      fwd_be        <= '0;
      fwd_wdata     <= '0;
    end else begin
      dp_resp_valid <= dp_valid;
      dp_resp_err   <= (bad || early) && err_rsp;
      fwd_valid     <= beat_ok;
      if (beat_ok) begin
        fwd_write <= dp_write;
        fwd_be    <= dp_be;
        fwd_wdata <= dp_wdata;
      end
    end
  end

  p_reject_silent_r5: assert property (@(posedge clk) disable iff (rst)
    (dp_valid && !beat_ok) |=> !fwd_valid);

  p_accept_ok_r8: assert property (@(posedge clk) disable iff (rst)
    beat_ok |=> (dp_resp_valid && !dp_resp_err));
endmodule

// File: rtl/sdma_regs.sv
module sdma_regs
  import sdma_pkg::*;
#(
  parameter int SIZE_W = 16,
  parameter int TAG_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  phase_t            phase,
  input  logic              set_err,
  input  logic              set_pause,
  input  logic              bus_err,
  input  logic [SIZE_W-1:0] size_q,
  input  logic [TAG_W-1:0]  tag_q,
  input  logic              dir_q,
  output logic              trig_clr,
  output logic              paused,
  output logic              err_rsp,
  output logic              irq
);
  logic       err_f;
  logic [1:0] ien;
  logic       last_fail, last_bus;
  logic       trig_f;
  logic       wr_stat, wr_ctrl, wr_last;

  assign trig_f  = (phase == PH_ARMED);
  assign wr_stat = reg_wr && (reg_addr == OFS_STAT);
  assign wr_ctrl = reg_wr && (reg_addr == OFS_CTRL);
  assign wr_last = reg_wr && (reg_addr == OFS_LAST);
  assign trig_clr = wr_stat && reg_wdata[0] && trig_f;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_f     <= 1'b0;
      paused    <= 1'b0;
      ien       <= '0;
      err_rsp   <= 1'b1;
      last_fail <= 1'b0;
      last_bus  <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (set_err)                     err_f <= 1'b1;
      else if (wr_stat && reg_wdata[1]) err_f <= 1'b0;

      if (set_pause)                   paused <= 1'b1;
      else if (wr_ctrl && reg_wdata[0]) paused <= 1'b0;

      if (reg_wr && reg_addr == OFS_IEN) ien     <= reg_wdata[1:0];
      if (reg_wr && reg_addr == OFS_SET) err_rsp <= reg_wdata[0];

      if (bus_err && phase != PH_IDLE) begin
        last_fail <= 1'b1;
        last_bus  <= 1'b1;
      end else if (wr_last) begin
        if (reg_wdata[0]) last_fail <= 1'b0;
        if (reg_wdata[1]) last_bus  <= 1'b0;
      end

      irq <= (trig_f && ien[0]) || (err_f && ien[1]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      reg_rdata <= '0;
      case (reg_addr)
        OFS_STAT: reg_rdata[1:0] <= {err_f, trig_f};
        OFS_IEN:  reg_rdata[1:0] <= ien;
        OFS_CTRL: reg_rdata[0]   <= paused;
        OFS_SET:  reg_rdata[0]   <= err_rsp;
        OFS_SIZE: reg_rdata[SIZE_W-1:0] <= size_q;
        OFS_TAG: begin
          reg_rdata[TAG_W-1:0] <= tag_q;
          reg_rdata[31]        <= dir_q;
        end
        OFS_LAST: reg_rdata[1:0] <= {last_bus, last_fail};
        default:  reg_rdata <= '0;
      endcase
    end
  end

  p_err_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    set_err |=> err_f);

  p_pause_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    set_pause |=> paused);

  p_idle_bus_err_r11: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE && !wr_last) |=> (last_fail == $past(last_fail)));
endmodule

// File: rtl/sdma_gate.sv
module sdma_gate
  import sdma_pkg::*;
#(
  parameter int DW     = 32,
  parameter int SIZE_W = 16,
  parameter int TAG_W  = 8,
  localparam int BE_W  = DW / 8,
  localparam int CNT_W = $clog2(BE_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [11:0]       reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              cmd_req,
  input  logic [SIZE_W-1:0] cmd_size,
  input  logic [TAG_W-1:0]  cmd_tag,
  input  logic              cmd_dir,
  output logic              cmd_ack,
  output logic              xfer_done,
  input  logic              dp_valid,
  input  logic              dp_write,
  input  logic [1:0]        dp_kind,
  input  logic [BE_W-1:0]   dp_be,
  input  logic [DW-1:0]     dp_wdata,
  output logic              dp_resp_valid,
  output logic              dp_resp_err,
  output logic              fwd_valid,
  output logic              fwd_write,
  output logic [BE_W-1:0]   fwd_be,
  output logic [DW-1:0]     fwd_wdata,
  input  logic              bus_err,
  output logic              irq
);
  phase_t            phase;
  logic              trig_clr, paused, err_rsp;
  logic              beat_ok, set_err, set_pause;
  logic [CNT_W-1:0]  beat_bytes;
  logic [SIZE_W-1:0] size_q;
  logic [TAG_W-1:0]  tag_q;
  logic              dir_q;

  sdma_seq #(.SIZE_W(SIZE_W), .TAG_W(TAG_W), .BE_W(BE_W)) u_seq (
    .clk, .rst, .cmd_req, .cmd_size, .cmd_tag, .cmd_dir,
    .paused, .trig_clr, .beat_ok, .beat_bytes,
    .phase, .cmd_ack, .xfer_done, .size_q, .tag_q, .dir_q
  );

  sdma_check #(.DW(DW), .BE_W(BE_W)) u_check (
    .clk, .rst, .dp_valid, .dp_write, .dp_kind, .dp_be, .dp_wdata,
    .phase, .dir_q, .err_rsp, .beat_ok, .set_err, .set_pause, .beat_bytes,
    .dp_resp_valid, .dp_resp_err, .fwd_valid, .fwd_write, .fwd_be, .fwd_wdata
  );

  sdma_regs #(.SIZE_W(SIZE_W), .TAG_W(TAG_W)) u_regs (
    .clk, .rst, .reg_wr, .reg_rd, .reg_addr, .reg_wdata, .reg_rdata,
    .phase, .set_err, .set_pause, .bus_err, .size_q, .tag_q, .dir_q,
    .trig_clr, .paused, .err_rsp, .irq
  );

  p_one_outcome_r8: assert property (@(posedge clk) disable iff (rst)
    !(fwd_valid && dp_resp_err));
endmodule

// File: tb/sim_sdma_gate.sv
module sim_sdma_gate;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 0, reg_rd = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cmd_req = 0;
  logic [15:0] cmd_size = '0;
  logic [7:0]  cmd_tag = '0;
  logic        cmd_dir = 0;
  logic        cmd_ack, xfer_done;
  logic        dp_valid = 0, dp_write = 0;
  logic [1:0]  dp_kind = '0;
  logic [3:0]  dp_be = '0;
  logic [31:0] dp_wdata = '0;
  logic        dp_resp_valid, dp_resp_err, fwd_valid, fwd_write;
  logic [3:0]  fwd_be;
  logic [31:0] fwd_wdata;
  logic        bus_err = 0;
  logic        irq;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  sdma_gate u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; d = reg_rdata;
  endtask

  task automatic beat(input logic w, input logic [1:0] k, input logic [3:0] be,
                      output logic rv, output logic re, output logic fv, output logic dn);
    @(negedge clk); dp_valid = 1; dp_write = w; dp_kind = k; dp_be = be;
    dp_wdata = {28'h0, be};
    @(negedge clk); dp_valid = 0;
    rv = dp_resp_valid; re = dp_resp_err; fv = fwd_valid; dn = xfer_done;
  endtask

  task automatic request(input int size, input int tag, input logic dir, output int wait_cyc);
    @(negedge clk); cmd_req = 1; cmd_size = 16'(size); cmd_tag = 8'(tag); cmd_dir = dir;
    wait_cyc = 0;
    while (!cmd_ack && wait_cyc < 50) begin @(negedge clk); wait_cyc++; end
    cmd_req = 0;
  endtask

  task automatic run_beats(input logic dir, input logic [3:0] be, output int n, output int fwd_bad);
    logic rv, re, fv, dn;
    n = 0; fwd_bad = 0; dn = 0;
    while (!dn && n < 40) begin
      beat(dir, 2'd0, be, rv, re, fv, dn);
      n++;
      if (!(rv && !re && fv && fwd_be == be && fwd_write == dir)) fwd_bad++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic rv, re, fv, dn;
    int wc, n, fb, pc, expn;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd(12'h110, d); chk("R1 status", d, 0);
    rd(12'h114, d); chk("R1 enable", d, 0);
    rd(12'h118, d); chk("R1 ctrl", d, 0);
    rd(12'h43C, d); chk("R1 settings", d, 1);
    rd(12'h440, d); chk("R1 size", d, 0);
    rd(12'h444, d); chk("R1 tag", d, 0);
    rd(12'h448, d); chk("R1 lastop", d, 0);
    chk("R1 irq", irq, 0);

    // R4 premature access with ERROR then OK response
    beat(1, 0, 4'hF, rv, re, fv, dn);
    chk("R4 resp valid", rv, 1); chk("R4 resp err", re, 1); chk("R4 no fwd", fv, 0);
    rd(12'h110, d); chk("R4 err flag", d, 2);
    rd(12'h118, d); chk("R4 no pause", d, 0);
    wr(12'h110, 32'h0); rd(12'h110, d); chk("R9 write0 keeps", d, 2);
    wr(12'h110, 32'h2); rd(12'h110, d); chk("R9 w1c", d, 0);
    wr(12'h43C, 32'h0);
    beat(0, 0, 4'h1, rv, re, fv, dn);
    chk("R4 ok resp", re, 0); chk("R4 ok resp no fwd", fv, 0);
    wr(12'h43C, 32'h1);

    // R10 irq on error flag
    wr(12'h114, 32'h2);
    repeat (2) @(negedge clk);
    chk("R10 irq err", irq, 1);
    wr(12'h110, 32'h2);
    repeat (2) @(negedge clk);
    chk("R10 irq clear", irq, 0);
    wr(12'h114, 32'h1);

    // R11 bus error in idle ignored
    @(negedge clk); bus_err = 1; @(negedge clk); bus_err = 0;
    rd(12'h448, d); chk("R11 idle ignored", d, 0);

    // R2 trigger
    request(6, 8'h5A, 1'b1, wc);
    chk("R2 ack", (wc < 50) ? 1 : 0, 1);
    rd(12'h110, d); chk("R2 trig", d, 1);
    rd(12'h440, d); chk("R2 size", d, 6);
    rd(12'h444, d); chk("R2 tag", d, 32'h8000005A);
    @(negedge clk); chk("R10 irq trig", irq, 1);

    // R11 bus error while triggered
    @(negedge clk); bus_err = 1; @(negedge clk); bus_err = 0;
    rd(12'h448, d); chk("R11 set", d, 3);
    wr(12'h448, 32'h3); rd(12'h448, d); chk("R11 w1c", d, 0);

    // R3 beat before clear is premature
    beat(1, 0, 4'hF, rv, re, fv, dn);
    chk("R3 before clear no fwd", fv, 0); chk("R3 before clear err", re, 1);
    wr(12'h110, 32'h2);
    wr(12'h110, 32'h1);
    rd(12'h110, d); chk("R3 trig cleared", d, 0);
    @(negedge clk); chk("R10 irq drops", irq, 0);

    // R6 wrong direction
    beat(0, 0, 4'hF, rv, re, fv, dn);
    chk("R6 no fwd", fv, 0); chk("R6 err resp", re, 1);
    rd(12'h110, d); chk("R6 err flag", d, 2);
    rd(12'h118, d); chk("R6 pause", d, 1);
    wr(12'h110, 32'h2); wr(12'h118, 32'h1);
    rd(12'h118, d); chk("R7 pause w1c", d, 0);

    // R5 unsupported kind
    beat(1, 2, 4'hF, rv, re, fv, dn);
    chk("R5 no fwd", fv, 0); chk("R5 err resp", re, 1);
    rd(12'h110, d); chk("R5 err flag", d, 2);
    rd(12'h118, d); chk("R5 pause", d, 1);
    wr(12'h110, 32'h2); wr(12'h118, 32'h1);

    // R8 finish 6 bytes: 4 then 2
    beat(1, 0, 4'hF, rv, re, fv, dn);
    chk("R8 fwd", fv, 1); chk("R8 ok", re, 0); chk("R8 not done", dn, 0);
    beat(1, 0, 4'h3, rv, re, fv, dn);
    chk("R8 fwd last", fv, 1); chk("R8 done", dn, 1);
    beat(1, 0, 4'hF, rv, re, fv, dn);
    chk("R8 closed", fv, 0);
    wr(12'h110, 32'h2);

    // R7 pause blocks trigger
    beat(1, 1, 4'h1, rv, re, fv, dn);
    rd(12'h118, d); chk("R7 paused", d, 1);
    @(negedge clk); cmd_req = 1; cmd_size = 16'd3; cmd_tag = 8'h21; cmd_dir = 0;
    wc = 0;
    repeat (6) begin @(negedge clk); if (cmd_ack) wc++; end
    chk("R7 no ack", wc, 0);
    rd(12'h110, d); chk("R7 no trig", d & 1, 0);
    wr(12'h118, 32'h1);
    wc = 0;
    while (!cmd_ack && wc < 10) begin @(negedge clk); wc++; end
    cmd_req = 0;
    chk("R7 ack after clear", (wc < 10) ? 1 : 0, 1);
    wr(12'h110, 32'h3);
    run_beats(0, 4'h3, n, fb);
    chk("R8 read xfer beats", n, 2); chk("R8 read xfer fwd", fb, 0);

    // R8 sweep: sizes 1..10, all byte-enable patterns
    for (int sz = 1; sz <= 10; sz++) begin
      for (int be = 1; be < 16; be++) begin
        pc = $countones(4'(be));
        expn = (sz + pc - 1) / pc;
        request(sz, sz * 16 + be, sz[0], wc);
        wr(12'h110, 32'h1);
        run_beats(sz[0], 4'(be), n, fb);
        chk($sformatf("R8 sweep size=%0d be=%0h beats", sz, be), n, expn);
        chk($sformatf("R8 sweep size=%0d be=%0h fwd", sz, be), fb, 0);
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule